// File: doc/BRIEF.md
# Opcode prefix sequence decoder

This block sits between instruction fetch and execute in an 8-bit accumulator CPU. It watches the stream of fetched opcode bytes and tags an instruction when one of two prefixes comes before it.

- A NOP placed in front of an instruction that uses the zero-page-indirect, Z-indexed mode makes that instruction use a 32-bit flat pointer.
- Two NEG opcodes placed in front of an instruction make it treat A, X, Y and Z as a single 32-bit register.
- Both prefixes may be used on the same instruction. In that case the order is NEG, NEG, NOP, then the target.

Every fetched byte is passed on unchanged, including the prefix bytes themselves. The prefixes are ordinary instructions with a harmless effect: a NOP does nothing, and two NEGs leave the accumulator as it was and only refresh N and Z. Because of this, the execute stage can run the prefix bytes as normal instructions and only needs to look at the two flags on the target. While a prefix is pending, the block holds off interrupts so that each prefixed sequence stays atomic.

A second unit inside the block fetches the 32-bit pointer for a far access. It reads four consecutive zero-page bytes and assembles them least significant first. It then adds Z to the pointer and delivers the effective address.

Top module: `opx_prefix_dec`

## Requirements
- R1: After reset, `op_valid_o`, `far_o`, `quad_o`, `irq_hold_o`, `zp_rd_o` and `ea_valid_o` are all low.
- R2: Every byte accepted with `op_valid_i` high appears on `op_o` unchanged, with `op_valid_o` high, one clock later. This includes prefix bytes. A flag is never high without `op_valid_o`.
- R3: NOP (0xEA) followed by an opcode whose low five bits are 10010 (0x12, 0x32, 0x52, 0x72, 0x92, 0xB2, 0xD2, 0xF2) gives that opcode `far_o` = 1 and `quad_o` = 0.
- R4: NEG (0x42), NEG, then any opcode other than NOP gives that opcode `quad_o` = 1 and `far_o` = 0.
- R5: NEG, NEG, NOP, then one of the opcodes listed in R3 gives the last opcode both `far_o` = 1 and `quad_o` = 1.
- R6: A byte that does not qualify after a partial prefix gets no flags and clears the pending prefix. That byte is then evaluated afresh, so a NEG or NOP in that position starts a new prefix.
- R7: `irq_hold_o` is high in the cycles after a prefix byte is accepted. It stays high until the target byte or the cancelling byte is accepted.
- R8: While `ext_en_i` is low, no flags are produced and `irq_hold_o` is low one cycle later. Bytes still pass through unchanged.
- R9: After `ptr_start_i`, the pointer unit issues exactly four reads with `zp_rd_o`. The addresses are `ptr_zp_i`, +1, +2 and +3, wrapping modulo 256.
- R10: The read data is assembled least significant byte first. `ptr_z_i`, zero-extended, is added to the result. The sum appears on `ea_o` with `ea_valid_o` high for exactly one cycle.
- R11: Cycles with `op_valid_i` low neither advance nor cancel a pending prefix.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_en_i | input | 1 | Enables prefix recognition |
| op_valid_i | input | 1 | A fetched opcode is present |
| op_i | input | 8 | Fetched opcode byte |
| op_valid_o | output | 1 | Decoded opcode is valid |
| op_o | output | 8 | Opcode passed through |
| far_o | output | 1 | Opcode uses a 32-bit zero-page pointer |
| quad_o | output | 1 | Opcode works on the combined 32-bit register |
| irq_hold_o | output | 1 | A prefix is pending; interrupts are held off |
| ptr_start_i | input | 1 | Start a far pointer fetch |
| ptr_zp_i | input | 8 | Zero-page operand of the far access |
| ptr_z_i | input | 8 | Value of register Z |
| zp_addr_o | output | 8 | Zero-page read address |
| zp_rd_o | output | 1 | Zero-page read strobe |
| zp_rdata_i | input | 8 | Read data, valid one cycle after the strobe |
| ea_o | output | 32 | Effective address: pointer plus Z |
| ea_valid_o | output | 1 | `ea_o` is valid (one-cycle pulse) |

## Verification
The assertions on pointer reads assume two things about the inputs:
- zero-page memory returns data exactly one cycle after each strobe;
- `ptr_start_i` is only raised while no fetch is in progress.

The bench models memory as a registered array and waits for `ea_valid_o` before starting the next fetch.

The assertions on prefix state assume that `ext_en_i` changes only between instructions. The bench therefore toggles it only in idle cycles, with `op_valid_i` low.

// File: rtl/opx_pkg.sv
package opx_pkg;
  localparam int unsigned OP_W = 8;
  localparam logic [OP_W-1:0] OPC_NOP = 8'hEA;
  localparam logic [OP_W-1:0] OPC_NEG = 8'h42;

  // zero-page indirect, Z-indexed opcodes: xxx1_0010
  function automatic logic is_zpz(input logic [OP_W-1:0] op);
    return op[4:0] == 5'b10010;
  endfunction
endpackage

// File: rtl/opx_pfx_track.sv
module opx_pfx_track
  import opx_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            valid_i,
  input  logic [OP_W-1:0] op_i,
  output logic            far_o,
  output logic            quad_o,
  output logic            pend_o
);
  logic [1:0] neg_q, neg_n;
  logic       nop_q, nop_n;
  logic       cancel;

  always_comb begin
    far_o  = 1'b0;
    quad_o = 1'b0;
    neg_n  = neg_q;
    nop_n  = nop_q;
    cancel = 1'b0;
    if (!en_i) begin
      neg_n = 2'd0;
      nop_n = 1'b0;
    end else if (valid_i) begin
      if (nop_q) begin
        if (is_zpz(op_i)) begin
          far_o  = 1'b1;
          quad_o = (neg_q == 2'd2);
          neg_n  = 2'd0;
          nop_n  = 1'b0;
        end else begin
          cancel = 1'b1;
        end
      end else if (neg_q == 2'd2) begin
        if (op_i == OPC_NOP) begin
          nop_n = 1'b1;
        end else begin
          quad_o = 1'b1;
          neg_n  = 2'd0;
        end
      end else if (neg_q == 2'd1) begin
        if (op_i == OPC_NEG) neg_n = 2'd2;
        else                 cancel = 1'b1;
      end else begin
        cancel = 1'b1;
      end
      // cancelling byte is re-evaluated from idle
      if (cancel) begin
        neg_n = (op_i == OPC_NEG) ? 2'd1 : 2'd0;
        nop_n = (op_i == OPC_NOP);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      neg_q <= 2'd0;
      nop_q <= 1'b0;
    end else begin
      neg_q <= neg_n;
      nop_q <= nop_n;
    end
  end

  assign pend_o = (neg_q != 2'd0) || nop_q;
endmodule

// File: rtl/opx_far_ptr.sv
module opx_far_ptr #(
  parameter int unsigned PTR_BYTES = 4,
  parameter int unsigned ZP_W      = 8,
  parameter int unsigned IDX_W     = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic [ZP_W-1:0]           zp_i,
  input  logic [IDX_W-1:0]          z_i,
  output logic [ZP_W-1:0]           addr_o,
  output logic                      rd_o,
  input  logic [7:0]                rdata_i,
  output logic [PTR_BYTES*8-1:0]    ea_o,
  output logic                      ea_valid_o
);
  localparam int unsigned PTR_W = PTR_BYTES * 8;
  localparam int unsigned CNT_W = $clog2(PTR_BYTES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PTR_BYTES - 1);
  localparam logic [CNT_W-1:0] NUM  = CNT_W'(PTR_BYTES);

  logic             busy_q, rd_q, eav_q;
  logic [CNT_W-1:0] iss_q, rcv_q;
  logic [ZP_W-1:0]  base_q;
  logic [IDX_W-1:0] z_q;
  logic [PTR_W-1:0] acc_q, ea_q, acc_sh;

  assign rd_o   = busy_q && (iss_q < NUM);
  assign addr_o = base_q + ZP_W'(iss_q);  // wraps within zero page
  assign acc_sh = {rdata_i, acc_q[PTR_W-1:8]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      eav_q  <= 1'b0;
      iss_q  <= '0;
      rcv_q  <= '0;
      base_q <= '0;
      z_q    <= '0;
      acc_q  <= '0;
      ea_q   <= '0;
    end else begin
      eav_q <= 1'b0;
      rd_q  <= rd_o;
      if (!busy_q) begin
        if (start_i) begin
          busy_q <= 1'b1;
          iss_q  <= '0;
          rcv_q  <= '0;
          base_q <= zp_i;
          z_q    <= z_i;
        end
      end else begin
        if (rd_o) iss_q <= iss_q + 1'b1;
        if (rd_q) begin
          acc_q <= acc_sh;
          rcv_q <= rcv_q + 1'b1;
          if (rcv_q == LAST) begin
            ea_q   <= acc_sh + PTR_W'(z_q);
            eav_q  <= 1'b1;
            busy_q <= 1'b0;
          end
        end
      end
    end
  end

  assign ea_o       = ea_q;
  assign ea_valid_o = eav_q;
endmodule

// File: rtl/opx_prefix_dec.sv
module opx_prefix_dec
  import opx_pkg::*;
#(
  parameter int unsigned PTR_BYTES = 4,
  parameter int unsigned ZP_W      = 8,
  parameter int unsigned IDX_W     = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   ext_en_i,
  input  logic                   op_valid_i,
  input  logic [OP_W-1:0]        op_i,
  output logic                   op_valid_o,
  output logic [OP_W-1:0]        op_o,
  output logic                   far_o,
  output logic                   quad_o,
  output logic                   irq_hold_o,
  input  logic                   ptr_start_i,
  input  logic [ZP_W-1:0]        ptr_zp_i,
  input  logic [IDX_W-1:0]       ptr_z_i,
  output logic [ZP_W-1:0]        zp_addr_o,
  output logic                   zp_rd_o,
  input  logic [7:0]             zp_rdata_i,
  output logic [PTR_BYTES*8-1:0] ea_o,
  output logic                   ea_valid_o
);
  logic far_d, quad_d, pend;

  opx_pfx_track i_track (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (ext_en_i),
    .valid_i(op_valid_i),
    .op_i   (op_i),
    .far_o  (far_d),
    .quad_o (quad_d),
    .pend_o (pend)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_valid_o <= 1'b0;
      op_o       <= '0;
      far_o      <= 1'b0;
      quad_o     <= 1'b0;
    end else begin
      op_valid_o <= op_valid_i;
      if (op_valid_i) op_o <= op_i;
      far_o  <= far_d;
      quad_o <= quad_d;
    end
  end

  assign irq_hold_o = pend;

  opx_far_ptr #(
    .PTR_BYTES(PTR_BYTES),
    .ZP_W     (ZP_W),
    .IDX_W    (IDX_W)
  ) i_far_ptr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (ptr_start_i),
    .zp_i      (ptr_zp_i),
    .z_i       (ptr_z_i),
    .addr_o    (zp_addr_o),
    .rd_o      (zp_rd_o),
    .rdata_i   (zp_rdata_i),
    .ea_o      (ea_o),
    .ea_valid_o(ea_valid_o)
  );
endmodule

// File: rtl/opx_prefix_dec_chk.sv
module opx_prefix_dec_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ext_en_i,
  input logic       op_valid_i,
  input logic [7:0] op_i,
  input logic       op_valid_o,
  input logic [7:0] op_o,
  input logic       far_o,
  input logic       quad_o,
  input logic       irq_hold_o,
  input logic [7:0] zp_addr_o,
  input logic       zp_rd_o,
  input logic       ea_valid_o
);
  AST_FLAG_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (far_o || quad_o) |-> op_valid_o); // R2
  AST_PASS_THROUGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i |=> (op_valid_o && op_o == $past(op_i))); // R2
  AST_FAR_ONLY_ZPZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    far_o |-> (op_o[4:0] == 5'b10010)); // R3
  AST_DISABLED_NO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_en_i |=> (!far_o && !quad_o && !irq_hold_o)); // R8
  AST_PREFIX_START_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && ext_en_i && !irq_hold_o && (op_i == 8'h42 || op_i == 8'hEA)) |=> irq_hold_o); // R7
  AST_BUBBLE_KEEPS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_hold_o && ext_en_i && !op_valid_i) |=> irq_hold_o); // R11
  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zp_rd_o && $past(zp_rd_o)) |-> (zp_addr_o == $past(zp_addr_o) + 8'd1)); // R9
  AST_EA_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ea_valid_o |=> !ea_valid_o); // R10
endmodule

bind opx_prefix_dec opx_prefix_dec_chk i_chk (.*);

// File: tb/test_opx_prefix_dec.sv
`timescale 1ns/1ps
module test_opx_prefix_dec;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ext_en_i = 1'b1;
  logic        op_valid_i = 1'b0;
  logic [7:0]  op_i = 8'h00;
  logic        op_valid_o, far_o, quad_o, irq_hold_o;
  logic [7:0]  op_o;
  logic        ptr_start_i = 1'b0;
  logic [7:0]  ptr_zp_i = 8'h00;
  logic [7:0]  ptr_z_i = 8'h00;
  logic [7:0]  zp_addr_o;
  logic        zp_rd_o;
  logic [7:0]  zp_rdata_i;
  logic [31:0] ea_o;
  logic        ea_valid_o;

  logic [7:0] mem [256];
  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic s_v, s_far, s_quad, s_hold;
  logic [7:0] s_op;

  always #2.5 clk_i = ~clk_i;

  always @(posedge clk_i) if (zp_rd_o) zp_rdata_i <= mem[zp_addr_o];

  opx_prefix_dec i_opx_prefix_dec (.*);

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] op);
    @(negedge clk_i);
    op_valid_i = 1'b1;
    op_i = op;
    @(posedge clk_i);
    #1;
    s_v = op_valid_o; s_op = op_o; s_far = far_o; s_quad = quad_o; s_hold = irq_hold_o;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      op_valid_i = 1'b0;
    end
  endtask

  task automatic t_reset;
    chk(op_valid_o, 0, "R1 op_valid");
    chk(far_o, 0, "R1 far");
    chk(quad_o, 0, "R1 quad");
    chk(irq_hold_o, 0, "R1 hold");
    chk(zp_rd_o, 0, "R1 zp_rd");
    chk(ea_valid_o, 0, "R1 ea_valid");
  endtask

  task automatic t_pass;
    send(8'hA9);
    chk(s_v, 1, "R2 valid"); chk(s_op, 8'hA9, "R2 op");
    chk({s_far, s_quad}, 0, "R2 no flag");
    send(8'hEA);
    chk(s_op, 8'hEA, "R2 nop passes"); chk(s_hold, 1, "R7 hold after nop");
    send(8'h12);
    chk(s_far, 1, "R3 far"); chk(s_quad, 0, "R3 quad"); chk(s_hold, 0, "R7 hold released");
    idle(1);
  endtask

  task automatic t_far_all;
    for (int k = 0; k < 8; k++) begin
      send(8'hEA);
      send({k[2:0], 5'b10010});
      chk(s_op, {24'd0, k[2:0], 5'b10010}, "R3 opcode");
      chk({s_far, s_quad}, 2'b10, "R3 far flag");
    end
    send(8'hEA);
    send(8'h11);
    chk({s_far, s_quad, s_hold}, 0, "R6 nop then non-zpz");
    idle(1);
  endtask

  task automatic t_quad;
    send(8'h42); chk(s_hold, 1, "R7 hold after neg");
    send(8'h42); chk(s_hold, 1, "R7 hold after neg neg");
    send(8'hAD);
    chk({s_far, s_quad}, 2'b01, "R4 quad"); chk(s_hold, 0, "R7 released");
    send(8'h42); send(8'h42); send(8'h12);
    chk({s_far, s_quad}, 2'b01, "R4 zpz without nop");
    idle(1);
  endtask

  task automatic t_combo;
    send(8'h42); send(8'h42); send(8'hEA);
    chk(s_hold, 1, "R7 hold after combo nop");
    send(8'hB2);
    chk({s_far, s_quad}, 2'b11, "R5 combined");
    chk(s_op, 8'hB2, "R5 op");
    idle(1);
  endtask

  task automatic t_cancel;
    send(8'h42); send(8'hA9);
    chk({s_far, s_quad, s_hold}, 0, "R6 neg cancelled");
    send(8'hEA); send(8'h42);
    chk(s_far, 0, "R6 nop cancelled by neg"); chk(s_hold, 1, "R6 neg restarts");
    send(8'h42); send(8'hA5);
    chk({s_far, s_quad}, 2'b01, "R6 restarted quad");
    send(8'h42); send(8'h42); send(8'hEA); send(8'hA9);
    chk({s_far, s_quad, s_hold}, 0, "R6 combo cancelled");
    send(8'h12);
    chk({s_far, s_quad}, 0, "R6 no stale prefix");
    idle(1);
  endtask

  task automatic t_bubble;
    send(8'hEA);
    idle(3);
    @(posedge clk_i); #1;
    chk(irq_hold_o, 1, "R11 hold over bubbles");
    send(8'h92);
    chk({s_far, s_quad}, 2'b10, "R11 far after bubbles");
    idle(1);
  endtask

  task automatic t_disabled;
    @(negedge clk_i); op_valid_i = 1'b0; ext_en_i = 1'b0;
    send(8'hEA); chk(s_hold, 0, "R8 no hold");
    send(8'h12); chk({s_far, s_quad}, 0, "R8 no far");
    send(8'h42); send(8'h42); send(8'hAD);
    chk({s_far, s_quad}, 0, "R8 no quad"); chk(s_op, 8'hAD, "R8 passes");
    idle(1);
    ext_en_i = 1'b1;
    send(8'hEA);
    idle(1);
    ext_en_i = 1'b0;
    @(posedge clk_i); #1;
    chk(irq_hold_o, 0, "R8 disable clears hold");
    @(negedge clk_i); ext_en_i = 1'b1;
    send(8'h12);
    chk(s_far, 0, "R8 pending dropped");
    idle(1);
  endtask

  task automatic t_ptr(input logic [7:0] zp, input logic [7:0] z);
    logic [7:0] addrs [8];
    int na = 0;
    logic [31:0] ea = 0, exp;
    bit got = 0;
    @(negedge clk_i);
    ptr_zp_i = zp; ptr_z_i = z; ptr_start_i = 1'b1;
    @(negedge clk_i);
    ptr_start_i = 1'b0;
    for (int c = 0; c < 20 && !got; c++) begin
      if (zp_rd_o && na < 8) begin addrs[na] = zp_addr_o; na++; end
      if (ea_valid_o) begin ea = ea_o; got = 1; end
      else @(negedge clk_i);
    end
    chk(got, 1, "R10 ea_valid seen");
    chk(na, 4, "R9 read count");
    for (int i = 0; i < 4; i++) chk(addrs[i], 8'(zp + 8'(i)), "R9 address");
    exp = {mem[8'(zp + 8'd3)], mem[8'(zp + 8'd2)], mem[8'(zp + 8'd1)], mem[zp]} + {24'd0, z};
    chk(ea, exp, "R10 effective address");
    @(negedge clk_i);
    chk(ea_valid_o, 0, "R10 one-cycle pulse");
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 11);
    #1;
    t_reset;
    #20 rst_ni = 1'b1;
    t_pass;
    t_far_all;
    t_quad;
    t_combo;
    t_cancel;
    t_bubble;
    t_disabled;
    t_ptr(8'hFD, 8'h80);
    t_ptr(8'h10, 8'hFF);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule